// File: doc/BRIEF.md
# Byte-wise NOR Flash Program Sequencer

This block copies a run of bytes from a source memory into an 8-bit parallel NOR flash. The flash needs a three-write unlock/command preamble before each data byte. One start pulse loads a configuration: source and destination base addresses, byte count, program command, a polling mask, and two unlock address/command pairs. The sequencer then runs on its own until the whole run is written or a byte fails.

For each byte the block reads the source, issues the preamble and the data write, waits one idle cycle, and polls the destination address. A byte is complete when the read value matches the written data on every bit selected by the polling mask. If it does not match, the bit two places below the mask bit acts as the device's timeout flag. While that flag is clear, polling continues. Once it is set, one last confirming read decides the byte. When the block finishes it pulses done and holds a result code.

Top module: `flash_prog_seq`

## Requirements
- R1: A start pulse while idle loads all settings, and busy is high from the next cycle. A start pulse while busy has no effect on the bus sequence or the result.
- R2: Each byte begins with one source read strobe at the current source address. The returned data is captured in the following cycle, before any flash write.
- R3: Each byte issues four single-cycle flash writes in consecutive cycles, in this order:
  - unlock command 1 to unlock address 1;
  - unlock command 2 to unlock address 2;
  - the program command to unlock address 1;
  - the data byte to the current destination address.
- R4: After the data write there is exactly one cycle with no bus activity, then a status read of the destination address. Flash read data is evaluated in the cycle after the read strobe.
- R5: A status read completes the byte when ((read XOR data) AND mask) is zero. Bits outside the mask are ignored.
- R6: If the comparison fails and (read AND (mask >> 2)) is zero, the block issues another status read in the cycle right after the evaluation.
- R7: If the comparison fails and (read AND (mask >> 2)) is non-zero, exactly one confirming status read follows. If it passes the comparison of R5, the byte succeeds.
- R8: If the confirming read fails the comparison, the run stops at once: no further bus activity, and done pulses with status 0x00.
- R9: After a successful byte that is not the last, the next byte starts in the following cycle at source and destination addresses each one higher, wrapping at their widths. After the last byte, done pulses with status 0x80.
- R10: A start with a count of zero pulses done in the next cycle with status 0x80. In that case busy stays low and no bus strobe is issued. No strobe is ever active while idle.
- R11: Done is a single-cycle pulse with busy low. Status is 0x00 after reset, changes only when done pulses, and holds its value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; loads the cfg_* inputs |
| cfg_src_addr | input | SRC_AW | Source base address |
| cfg_dst_addr | input | FL_AW | Flash destination base address |
| cfg_count | input | CNT_W | Number of bytes to program |
| cfg_prog_cmd | input | 8 | Program command byte |
| cfg_poll_mask | input | 8 | Completion bit mask; timeout bit is mask >> 2 |
| cfg_ul1_addr | input | FL_AW | First unlock address |
| cfg_ul1_cmd | input | 8 | First unlock command |
| cfg_ul2_addr | input | FL_AW | Second unlock address |
| cfg_ul2_cmd | input | 8 | Second unlock command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 8 | Result: 0x80 success, 0x00 failure |
| src_rd_en | output | 1 | Source read strobe |
| src_rd_addr | output | SRC_AW | Source read address |
| src_rd_data | input | 8 | Source data, valid one cycle after the strobe |
| fl_wr_en | output | 1 | Flash write strobe |
| fl_rd_en | output | 1 | Flash read strobe |
| fl_addr | output | FL_AW | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid one cycle after the read strobe |

## Verification
The bench builds the block with SRC_AW=8, FL_AW=12 and CNT_W=4. At these widths a 15-byte run (the largest count) is short enough to run in full. The small widths also let both address pointers cross their wrap point within one run. Two polling masks are used: 0x80, and 0x40, which moves the timeout bit to 0x10. With these settings the bench drives immediate completion, several plain busy polls, a timeout that is confirmed good, a timeout that is confirmed bad, a zero count, and a start pulse that arrives mid-run.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CAPT,
    ST_UL1,
    ST_UL2,
    ST_CMD,
    ST_DATA,
    ST_GAP,
    ST_RD,
    ST_EVAL,
    ST_RD2,
    ST_EVAL2
  } fps_state_e;

  localparam logic [7:0] FPS_OK  = 8'h80;
  localparam logic [7:0] FPS_ERR = 8'h00;

endpackage

// File: rtl/prog_poll_eval.sv
module prog_poll_eval #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] rd_val,
  input  logic [DW-1:0] wr_val,
  input  logic [DW-1:0] mask,
  output logic          match,
  output logic          tmo
);

  localparam int TMO_SHIFT = 2;

  logic [DW-1:0] diff;
  logic [DW-1:0] tmo_mask;

  always_comb begin
    diff     = (rd_val ^ wr_val) & mask;
    tmo_mask = mask >> TMO_SHIFT;
    match    = (diff == '0);
    tmo      = |(rd_val & tmo_mask);
  end

endmodule

// File: rtl/prog_ctx.sv
module prog_ctx #(
  parameter int SRC_AW = 24,
  parameter int FL_AW  = 24,
  parameter int CNT_W  = 16,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cap,
  input  logic              adv,
  input  logic [SRC_AW-1:0] cfg_src_addr,
  input  logic [FL_AW-1:0]  cfg_dst_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [DW-1:0]     cfg_prog_cmd,
  input  logic [DW-1:0]     cfg_poll_mask,
  input  logic [FL_AW-1:0]  cfg_ul1_addr,
  input  logic [DW-1:0]     cfg_ul1_cmd,
  input  logic [FL_AW-1:0]  cfg_ul2_addr,
  input  logic [DW-1:0]     cfg_ul2_cmd,
  input  logic [DW-1:0]     src_rd_data,
  output logic [SRC_AW-1:0] src_addr,
  output logic [FL_AW-1:0]  dst_addr,
  output logic [DW-1:0]     data,
  output logic [DW-1:0]     prog_cmd,
  output logic [DW-1:0]     poll_mask,
  output logic [FL_AW-1:0]  ul1_addr,
  output logic [DW-1:0]     ul1_cmd,
  output logic [FL_AW-1:0]  ul2_addr,
  output logic [DW-1:0]     ul2_cmd,
  output logic              cnt_last
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // Per-run settings, loaded once per start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_cmd  <= '0;
      poll_mask <= '0;
      ul1_addr  <= '0;
      ul1_cmd   <= '0;
      ul2_addr  <= '0;
      ul2_cmd   <= '0;
    end else if (load) begin
      prog_cmd  <= cfg_prog_cmd;
      poll_mask <= cfg_poll_mask;
      ul1_addr  <= cfg_ul1_addr;
      ul1_cmd   <= cfg_ul1_cmd;
      ul2_addr  <= cfg_ul2_addr;
      ul2_cmd   <= cfg_ul2_cmd;
    end
  end

  // Moving pointers and the remaining byte count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr <= '0;
      dst_addr <= '0;
      cnt_q    <= '0;
    end else if (load) begin
      src_addr <= cfg_src_addr;
      dst_addr <= cfg_dst_addr;
      cnt_q    <= cfg_count;
    end else if (adv) begin
      src_addr <= src_addr + SRC_AW'(1);
      dst_addr <= dst_addr + FL_AW'(1);
      cnt_q    <= cnt_q - CNT_ONE;
    end
  end

  // The byte to program, captured from the source port.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
    end else if (cap) begin
      data <= src_rd_data;
    end
  end

  assign cnt_last = (cnt_q == CNT_ONE);

endmodule

// File: rtl/prog_ctrl.sv
module prog_ctrl
  import flash_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cnt_zero,
  input  logic       cnt_last,
  input  logic       match,
  input  logic       tmo,
  output fps_state_e state,
  output logic       load,
  output logic       cap,
  output logic       adv,
  output logic       done,
  output logic [7:0] status
);

  fps_state_e st_q, st_d;
  logic       fin, fin_ok;
  logic       done_q;
  logic [7:0] status_q;

  // Next-state process.
  always_comb begin
    st_d   = st_q;
    load   = 1'b0;
    cap    = 1'b0;
    adv    = 1'b0;
    fin    = 1'b0;
    fin_ok = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          load = 1'b1;
          if (cnt_zero) begin
            fin    = 1'b1;
            fin_ok = 1'b1;
          end else begin
            st_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: st_d = ST_CAPT;
      ST_CAPT: begin
        cap  = 1'b1;
        st_d = ST_UL1;
      end
      ST_UL1:  st_d = ST_UL2;
      ST_UL2:  st_d = ST_CMD;
      ST_CMD:  st_d = ST_DATA;
      ST_DATA: st_d = ST_GAP;
      ST_GAP:  st_d = ST_RD;
      ST_RD:   st_d = ST_EVAL;
      ST_EVAL: begin
        if (match) begin
          if (cnt_last) begin
            fin    = 1'b1;
            fin_ok = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            adv  = 1'b1;
            st_d = ST_FETCH;
          end
        end else if (tmo) begin
          st_d = ST_RD2;
        end else begin
          st_d = ST_RD;
        end
      end
      ST_RD2: st_d = ST_EVAL2;
      ST_EVAL2: begin
        if (match) begin
          if (cnt_last) begin
            fin    = 1'b1;
            fin_ok = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            adv  = 1'b1;
            st_d = ST_FETCH;
          end
        end else begin
          fin  = 1'b1;
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      done_q   <= 1'b0;
      status_q <= FPS_ERR;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      if (fin) begin
        status_q <= fin_ok ? FPS_OK : FPS_ERR;
      end
    end
  end

  assign state  = st_q;
  assign done   = done_q;
  assign status = status_q;

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int SRC_AW = 24,
  parameter int FL_AW  = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SRC_AW-1:0] cfg_src_addr,
  input  logic [FL_AW-1:0]  cfg_dst_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [7:0]        cfg_prog_cmd,
  input  logic [7:0]        cfg_poll_mask,
  input  logic [FL_AW-1:0]  cfg_ul1_addr,
  input  logic [7:0]        cfg_ul1_cmd,
  input  logic [FL_AW-1:0]  cfg_ul2_addr,
  input  logic [7:0]        cfg_ul2_cmd,
  output logic              busy,
  output logic              done,
  output logic [7:0]        status,
  output logic              src_rd_en,
  output logic [SRC_AW-1:0] src_rd_addr,
  input  logic [7:0]        src_rd_data,
  output logic              fl_wr_en,
  output logic              fl_rd_en,
  output logic [FL_AW-1:0]  fl_addr,
  output logic [7:0]        fl_wdata,
  input  logic [7:0]        fl_rdata
);

  localparam int DW = 8;

  fps_state_e        state;
  logic              load, cap, adv;
  logic              cnt_last, match, tmo;
  logic [SRC_AW-1:0] src_addr;
  logic [FL_AW-1:0]  dst_addr, ul1_addr, ul2_addr;
  logic [DW-1:0]     data, prog_cmd, poll_mask, ul1_cmd, ul2_cmd;

  prog_ctx #(
    .SRC_AW(SRC_AW), .FL_AW(FL_AW), .CNT_W(CNT_W), .DW(DW)
  ) u_ctx (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .cap          (cap),
    .adv          (adv),
    .cfg_src_addr (cfg_src_addr),
    .cfg_dst_addr (cfg_dst_addr),
    .cfg_count    (cfg_count),
    .cfg_prog_cmd (cfg_prog_cmd),
    .cfg_poll_mask(cfg_poll_mask),
    .cfg_ul1_addr (cfg_ul1_addr),
    .cfg_ul1_cmd  (cfg_ul1_cmd),
    .cfg_ul2_addr (cfg_ul2_addr),
    .cfg_ul2_cmd  (cfg_ul2_cmd),
    .src_rd_data  (src_rd_data),
    .src_addr     (src_addr),
    .dst_addr     (dst_addr),
    .data         (data),
    .prog_cmd     (prog_cmd),
    .poll_mask    (poll_mask),
    .ul1_addr     (ul1_addr),
    .ul1_cmd      (ul1_cmd),
    .ul2_addr     (ul2_addr),
    .ul2_cmd      (ul2_cmd),
    .cnt_last     (cnt_last)
  );

  prog_poll_eval #(.DW(DW)) u_eval (
    .rd_val(fl_rdata),
    .wr_val(data),
    .mask  (poll_mask),
    .match (match),
    .tmo   (tmo)
  );

  prog_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cnt_zero(cfg_count == '0),
    .cnt_last(cnt_last),
    .match   (match),
    .tmo     (tmo),
    .state   (state),
    .load    (load),
    .cap     (cap),
    .adv     (adv),
    .done    (done),
    .status  (status)
  );

  // Bus strobes and address/data steering decoded from the state.
  always_comb begin
    busy        = (state != ST_IDLE);
    src_rd_en   = (state == ST_FETCH);
    src_rd_addr = src_addr;
    fl_wr_en    = (state == ST_UL1) || (state == ST_UL2) ||
                  (state == ST_CMD) || (state == ST_DATA);
    fl_rd_en    = (state == ST_RD) || (state == ST_RD2);
    case (state)
      ST_UL1: begin
        fl_addr  = ul1_addr;
        fl_wdata = ul1_cmd;
      end
      ST_UL2: begin
        fl_addr  = ul2_addr;
        fl_wdata = ul2_cmd;
      end
      ST_CMD: begin
        fl_addr  = ul1_addr;
        fl_wdata = prog_cmd;
      end
      default: begin
        fl_addr  = dst_addr;
        fl_wdata = data;
      end
    endcase
  end

endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [7:0] status,
  input logic       src_rd_en,
  input logic       fl_wr_en,
  input logic       fl_rd_en
);

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy || done)); // R1

  AST_CAPTURE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_en |=> (!fl_wr_en && !src_rd_en)); // R2

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_wr_en && fl_rd_en)); // R3

  AST_NO_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_wr_en |=> !fl_rd_en); // R4

  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status == 8'h80 || status == 8'h00)); // R9

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(src_rd_en || fl_wr_en || fl_rd_en)); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done); // R11

  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status)); // R11

endmodule

bind flash_prog_seq flash_prog_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .status   (status),
  .src_rd_en(src_rd_en),
  .fl_wr_en (fl_wr_en),
  .fl_rd_en (fl_rd_en)
);

// File: tb/test_flash_prog_seq.sv
`timescale 1ns/1ps
module test_flash_prog_seq;

  localparam int SAW = 8;
  localparam int FAW = 12;
  localparam int CW  = 4;

  typedef struct {
    bit         busy;
    bit         src;
    bit         wr;
    bit         rd;
    bit         dn;
    int         addr;
    logic [7:0] data;
    logic [7:0] stat;
    int         req;
  } exp_t;

  logic           clk, rst_n, start;
  logic [SAW-1:0] cfg_src_addr;
  logic [FAW-1:0] cfg_dst_addr, cfg_ul1_addr, cfg_ul2_addr;
  logic [CW-1:0]  cfg_count;
  logic [7:0]     cfg_prog_cmd, cfg_poll_mask, cfg_ul1_cmd, cfg_ul2_cmd;
  logic           busy, done, src_rd_en, fl_wr_en, fl_rd_en;
  logic [7:0]     status, src_rd_data, fl_wdata, fl_rdata;
  logic [SAW-1:0] src_rd_addr;
  logic [FAW-1:0] fl_addr;

  exp_t       expq[$];
  logic [7:0] rdq[$];
  logic [7:0] srcmem [256];
  int         sc_busy [16];
  int         sc_kind [16];
  int         checks, errors;
  bit         run_cmp;
  logic [7:0] last_stat;

  flash_prog_seq #(.SRC_AW(SAW), .FL_AW(FAW), .CNT_W(CW)) i_flash_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_count(cfg_count), .cfg_prog_cmd(cfg_prog_cmd),
    .cfg_poll_mask(cfg_poll_mask), .cfg_ul1_addr(cfg_ul1_addr),
    .cfg_ul1_cmd(cfg_ul1_cmd), .cfg_ul2_addr(cfg_ul2_addr),
    .cfg_ul2_cmd(cfg_ul2_cmd), .busy(busy), .done(done), .status(status),
    .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
    .fl_wr_en(fl_wr_en), .fl_rd_en(fl_rd_en), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic string rq_name(int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic void push(bit b, bit s, bit w, bit r, bit d, int a,
                               logic [7:0] dt, logic [7:0] st, int rq);
    exp_t e;
    e.busy = b; e.src = s; e.wr = w; e.rd = r; e.dn = d;
    e.addr = a; e.data = dt; e.stat = st; e.req = rq;
    expq.push_back(e);
  endfunction

  // Source memory and flash models: one-cycle read latency.
  always @(posedge clk) begin
    if (src_rd_en) src_rd_data <= srcmem[src_rd_addr];
    if (fl_rd_en) fl_rdata <= (rdq.size() > 0) ? rdq.pop_front() : 8'h00;
  end

  // Cycle-by-cycle comparison against the expected trace.
  always @(negedge clk) begin
    if (run_cmp) begin
      exp_t e;
      bit   bad;
      if (expq.size() > 0) e = expq.pop_front();
      else begin
        e.busy = 0; e.src = 0; e.wr = 0; e.rd = 0; e.dn = 0;
        e.addr = 0; e.data = 0; e.stat = 0; e.req = 11;
      end
      checks++;
      bad = (busy != e.busy) || (src_rd_en != e.src) || (fl_wr_en != e.wr) ||
            (fl_rd_en != e.rd) || (done != e.dn);
      if (e.src && (int'(src_rd_addr) != e.addr)) bad = 1;
      if (e.wr && ((int'(fl_addr) != e.addr) || (fl_wdata != e.data))) bad = 1;
      if (e.rd && (int'(fl_addr) != e.addr)) bad = 1;
      if (e.dn && (status != e.stat)) bad = 1;
      if (bad) begin
        errors++;
        $display("FAIL %s t=%0t got busy=%0b src=%0b wr=%0b rd=%0b done=%0b sa=%h fa=%h wd=%h st=%h exp busy=%0b src=%0b wr=%0b rd=%0b done=%0b a=%h d=%h st=%h",
                 rq_name(e.req), $time, busy, src_rd_en, fl_wr_en, fl_rd_en, done,
                 src_rd_addr, fl_addr, fl_wdata, status, e.busy, e.src, e.wr,
                 e.rd, e.dn, e.addr, e.data, e.stat);
      end
    end
  end

  task automatic launch(int src, int dst, int cnt, logic [7:0] pcmd,
                        logic [7:0] m, int u1a, logic [7:0] u1c,
                        int u2a, logic [7:0] u2c);
    logic [7:0] m2, d, busyv, tmov, okv;
    @(posedge clk); #1;
    cfg_src_addr = SAW'(src); cfg_dst_addr = FAW'(dst); cfg_count = CW'(cnt);
    cfg_prog_cmd = pcmd; cfg_poll_mask = m;
    cfg_ul1_addr = FAW'(u1a); cfg_ul1_cmd = u1c;
    cfg_ul2_addr = FAW'(u2a); cfg_ul2_cmd = u2c;
    start = 1'b1;
    m2 = m >> 2;
    push(0, 0, 0, 0, 0, 0, 0, 0, 1);              // R1 start cycle still idle
    if (cnt == 0) begin
      push(0, 0, 0, 0, 1, 0, 0, 8'h80, 10);       // R10 immediate done
      last_stat = 8'h80;
    end else begin
      for (int k = 0; k < cnt; k++) begin
        int as, ad;
        as = (src + k) % 256;
        ad = (dst + k) % 4096;
        d  = srcmem[as];
        busyv = (d ^ m) & ~m2;
        tmov  = (d ^ m) | m2;
        okv   = d ^ (8'h0F & ~m & ~m2);
        push(1, 1, 0, 0, 0, as, 0, 0, (k == 0) ? 1 : 9); // R1 busy, R9 advance
        push(1, 0, 0, 0, 0, 0, 0, 0, 2);                  // R2 capture cycle
        push(1, 0, 1, 0, 0, u1a, u1c, 0, 3);              // R3 order
        push(1, 0, 1, 0, 0, u2a, u2c, 0, 3);
        push(1, 0, 1, 0, 0, u1a, pcmd, 0, 3);
        push(1, 0, 1, 0, 0, ad, d, 0, 3);
        push(1, 0, 0, 0, 0, 0, 0, 0, 4);                  // R4 idle gap
        for (int j = 0; j < sc_busy[k]; j++) begin
          push(1, 0, 0, 1, 0, ad, 0, 0, 6);               // R6 repoll
          push(1, 0, 0, 0, 0, 0, 0, 0, 6);
          rdq.push_back(busyv);
        end
        if (sc_kind[k] == 0) begin
          push(1, 0, 0, 1, 0, ad, 0, 0, 5);               // R5 masked match
          push(1, 0, 0, 0, 0, 0, 0, 0, 5);
          rdq.push_back(okv);
        end else begin
          push(1, 0, 0, 1, 0, ad, 0, 0, 7);               // R7 timeout flag seen
          push(1, 0, 0, 0, 0, 0, 0, 0, 7);
          rdq.push_back(tmov);
          push(1, 0, 0, 1, 0, ad, 0, 0, 7);               // R7 confirming read
          push(1, 0, 0, 0, 0, 0, 0, 0, 7);
          rdq.push_back((sc_kind[k] == 1) ? okv : tmov);
        end
        if (sc_kind[k] == 2) begin
          push(0, 0, 0, 0, 1, 0, 0, 8'h00, 8);            // R8 failure
          last_stat = 8'h00;
          break;
        end
        if (k == cnt - 1) begin
          push(0, 0, 0, 0, 1, 0, 0, 8'h80, 9);            // R9 success
          last_stat = 8'h80;
        end
      end
    end
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic finish_run();
    wait (expq.size() == 0);
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (status !== last_stat) begin   // R11 status held after done
      errors++;
      $display("FAIL R11 status held: got %h expected %h", status, last_stat);
    end
  endtask

  task automatic set_scen(int n, int nb, int kd);
    sc_busy[n] = nb;
    sc_kind[n] = kd;
  endtask

  initial begin
    checks = 0; errors = 0; run_cmp = 0;
    start = 0; rst_n = 0; last_stat = 8'h00;
    cfg_src_addr = '0; cfg_dst_addr = '0; cfg_count = '0;
    cfg_prog_cmd = '0; cfg_poll_mask = '0; cfg_ul1_addr = '0;
    cfg_ul1_cmd = '0; cfg_ul2_addr = '0; cfg_ul2_cmd = '0;
    src_rd_data = '0; fl_rdata = '0;
    for (int i = 0; i < 256; i++) srcmem[i] = 8'((i * 37 + 5) & 255);
    for (int i = 0; i < 16; i++) set_scen(i, 0, 0);
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || status !== 8'h00) begin // R11 reset
      errors++;
      $display("FAIL R11 reset: got busy=%b done=%b status=%h expected 0 0 00",
               busy, done, status);
    end
    @(posedge clk); #1;
    rst_n = 1;
    run_cmp = 1;

    // Three bytes: immediate, two busy polls, timeout confirmed good.
    set_scen(0, 0, 0); set_scen(1, 2, 0); set_scen(2, 1, 1);
    launch(16, 12'h100, 3, 8'hA0, 8'h80, 12'h555, 8'hAA, 12'h2AA, 8'h55);
    finish_run();

    // Second byte fails after timeout; a start mid-run must be ignored (R1).
    set_scen(0, 1, 0); set_scen(1, 0, 2); set_scen(2, 0, 0);
    launch(40, 12'h200, 3, 8'hA0, 8'h80, 12'h555, 8'hAA, 12'h2AA, 8'h55);
    repeat (6) @(posedge clk); #1;
    start = 1; cfg_count = 4'd7; cfg_src_addr = 8'd0; cfg_prog_cmd = 8'h11;
    @(posedge clk); #1;
    start = 0;
    finish_run();

    // Zero count (R10).
    launch(0, 0, 0, 8'hA0, 8'h80, 12'h555, 8'hAA, 12'h2AA, 8'h55);
    finish_run();

    // Different mask: completion bit 0x40, timeout bit 0x10.
    set_scen(0, 1, 1); set_scen(1, 3, 0);
    launch(77, 12'h321, 2, 8'h33, 8'h40, 12'h0AB, 8'h5C, 12'h0CD, 8'hC5);
    finish_run();

    // Maximum count with both pointers wrapping (R9).
    for (int i = 0; i < 16; i++) set_scen(i, i % 2, 0);
    launch(250, 12'hFFA, 15, 8'hA0, 8'h80, 12'h555, 8'hAA, 12'h2AA, 8'h55);
    finish_run();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: run did not finish, got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule